// File: doc/BRIEF.md
# BCD Calendar Time Counter Chain

This block keeps wall-clock time and calendar date as a chain of packed-BCD registers. The chain starts at thousandths of a second and ends at the month. A one-cycle tick enable at 1 kHz advances the lowest digit. Every carry resolves in the same clock cycle, so all eight registers change together on the tick edge. Time uses a 24-hour format. The calendar has fixed month lengths and no leap-year correction.

Software reaches the block through a simple synchronous 8-bit port. Each access lasts one cycle. The eight time registers sit at addresses 00h to 07h, in order from the lowest digit to the highest. Each register holds two BCD digits. Three further addresses provide control:
- a command that clears all counters,
- a command that starts the clock precisely on a minute,
- a rollover flag that tells software a counter read may have overlapped a tick and should be repeated.

Top module: `rtc_bcd_chain`

## Requirements
- R1: After reset, registers 00h to 04h read 00h, registers 05h, 06h and 07h read 01h, and address 14h reads 00h.
- R2: Each counter register stores and returns only its legal bits. The masks are 00h:F0h, 01h:FFh, 02h:7Fh, 03h:7Fh, 04h:3Fh, 05h:07h, 06h:3Fh, 07h:1Fh. Masked-off bits read as zero. The low nibble of 00h always reads zero.
- R3: Each tick advances the thousandths digit (bits 7:4 of 00h) from 0 to 9. Each time a register passes its maximum, it returns to zero and advances the next register. The limits are: 01h (hundredths in bits 3:0, tenths in bits 7:4) 00 to 99; seconds 00 to 59; minutes 00 to 59; hours 00 to 23.
- R4: When hours roll from 23 to 00, both day of week and day of month advance. Day of week counts 01 to 07 and then wraps to 01.
- R5: Day of month counts from 01 up to the limit for the current month. The limits are 31, 28, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31 for months 01 to 12, with February always 28. Passing the limit wraps day of month to 01 and advances the month. Month counts 01 to 12 and then wraps to 01.
- R6: A bus write to a counter register in the same cycle as a tick stores the written value in that register, and the tick increment for that register is lost.
- R7: Writing FFh to address 12h returns every counter to its reset value. Writing any other value to 12h changes nothing.
- R8: Any write to address 15h clears registers 00h, 01h and 02h, whatever the write data. If seconds were above 39 at that moment, minutes advance by one and carry onward as a normal minute rollover would. Otherwise minutes stay unchanged.
- R9: A read of address 14h returns the rollover flag in bit 0, with bits 7:1 zero. The flag is set by a tick in the same cycle as a counter read (00h to 07h), or by a tick in any later cycle before the next read of 14h. A read of 14h clears the flag and cancels any earlier counter reads, so a tick after that read does not set the flag.
- R10: A read of any address other than 00h to 07h and 14h returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 kHz advance enable, one cycle wide |
| bus_valid_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |

## Verification
The bench starts from calendar points that sit just before a rollover and checks that the whole carry ripples through in one tick. These points include a plain BCD digit carry (09 to 10), the hour wrap into both day counters, February 28, 30-day months, month 09, and December 31. A chain that compared against the wrong month limit, or left out one of the day counters, would produce a wrong date at these points.

The minute-start command is tested at seconds 45, 39 and 50:59. A design that rounds at the wrong threshold, or that fails to carry into hours, would show it here.

For the rollover flag, the bench checks a tick in the same cycle as a counter read, a tick in a later cycle, and a tick after the flag has already been read. A flag that clears too early, or that stays armed after it is read, would give the wrong result in one of these cases.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_N  = 8;
  localparam int ADDR_W = 5;
  localparam int IDX_W  = $clog2(CNT_N);

  localparam logic [ADDR_W-1:0] ADR_CLR  = 5'h12;
  localparam logic [ADDR_W-1:0] ADR_STAT = 5'h14;
  localparam logic [ADDR_W-1:0] ADR_GO   = 5'h15;
  localparam logic [BYTE_W-1:0] CLR_KEY  = 8'hFF;

  typedef logic [BYTE_W-1:0] cnt_byte_t;
  typedef logic [CNT_N-1:0][BYTE_W-1:0] cnt_vec_t;

  // legal bits per register
  function automatic cnt_byte_t cnt_mask(input int idx);
    case (idx)
      0: return 8'hF0;
      1: return 8'hFF;
      2: return 8'h7F;
      3: return 8'h7F;
      4: return 8'h3F;
      5: return 8'h07;
      6: return 8'h3F;
      default: return 8'h1F;
    endcase
  endfunction

  function automatic cnt_byte_t cnt_rst(input int idx);
    return (idx >= 5) ? 8'h01 : 8'h00;
  endfunction

  // fixed wrap limits; day of month is dynamic
  function automatic cnt_byte_t cnt_max(input int idx);
    case (idx)
      0: return 8'h90;
      1: return 8'h99;
      2: return 8'h59;
      3: return 8'h59;
      4: return 8'h23;
      5: return 8'h07;
      6: return 8'h31;
      default: return 8'h12;
    endcase
  endfunction

  function automatic cnt_byte_t mon_limit(input cnt_byte_t mon);
    case (mon)
      8'h02: return 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  function automatic cnt_byte_t bcd_inc(input cnt_byte_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic cnt_vec_t rst_all();
    cnt_vec_t r;
    for (int i = 0; i < CNT_N; i++) r[i] = cnt_rst(i);
    return r;
  endfunction
endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   go_i,
  input  logic                   clr_i,
  input  logic [CNT_N-1:0]       wr_en_i,
  input  logic [BYTE_W-1:0]      wdata_i,
  output cnt_vec_t               cnt_o
);
  localparam int GO_LAST = 2;

  cnt_vec_t cnt_q;
  cnt_vec_t inc_v;
  cnt_vec_t max_v;
  logic [CNT_N-1:0] wrap;
  logic [CNT_N-1:0] adv;

  always_comb begin
    for (int i = 0; i < CNT_N; i++) begin
      max_v[i] = (i == 6) ? mon_limit(cnt_q[7]) : cnt_max(i);
      wrap[i]  = cnt_q[i] >= max_v[i];
      if (wrap[i])     inc_v[i] = cnt_rst(i);
      else if (i == 0) inc_v[i] = {bcd_inc({4'd0, cnt_q[i][7:4]})[3:0], 4'd0};
      else             inc_v[i] = bcd_inc(cnt_q[i]);
    end
  end

  // carry chain; hour rollover feeds both day counters
  always_comb begin
    adv[0] = tick_i & ~go_i;
    adv[1] = adv[0] & wrap[0];
    adv[2] = adv[1] & wrap[1];
    adv[3] = go_i ? (cnt_q[2] > 8'h39) : (adv[2] & wrap[2]);
    adv[4] = adv[3] & wrap[3];
    adv[5] = adv[4] & wrap[4];
    adv[6] = adv[5];
    adv[7] = adv[6] & wrap[6];
  end

  for (genvar g = 0; g < CNT_N; g++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q[g] <= cnt_rst(g);
      else if (clr_i)           cnt_q[g] <= cnt_rst(g);
      else if (wr_en_i[g])      cnt_q[g] <= wdata_i & cnt_mask(g);
      else if (go_i && g <= GO_LAST) cnt_q[g] <= '0;
      else if (adv[g])          cnt_q[g] <= inc_v[g];
    end
  end

  assign cnt_o = cnt_q;

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !go_i && !clr_i && wr_en_i == '0) |=> $stable(cnt_q));
  p_ms_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !go_i && !clr_i && !wr_en_i[0]) |=> cnt_q[0] != $past(cnt_q[0]));
  p_write_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i[1] && !clr_i) |=> cnt_q[1] == $past(wdata_i));
  p_clr_all_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == rst_all());
  p_go_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && !clr_i) |=> cnt_q[2:0] == '0);
endmodule

// File: rtl/rtc_roll_flag.sv
module rtc_roll_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cnt_rd_i,
  input  logic stat_rd_i,
  output logic flag_o
);
  logic armed_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else if (stat_rd_i) begin
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (cnt_rd_i) armed_q <= 1'b1;
      if (tick_i && (armed_q || cnt_rd_i)) flag_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  p_flag_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i |=> !flag_o);
  p_flag_same_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_rd_i && !stat_rd_i) |=> flag_o);
endmodule

// File: rtl/rtc_rd_mux.sv
module rtc_rd_mux
  import rtc_pkg::*;
(
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  cnt_vec_t          cnt_i,
  input  logic              flag_i,
  output logic [BYTE_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (addr_i < ADDR_W'(CNT_N)) rdata_o = cnt_i[addr_i[IDX_W-1:0]];
      else if (addr_i == ADR_STAT) rdata_o = {{(BYTE_W-1){1'b0}}, flag_i};
    end
  end
endmodule

// File: rtl/rtc_bcd_chain.sv
module rtc_bcd_chain
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              bus_valid_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o
);
  logic wr, rd, clr, go, cnt_rd, stat_rd, flag;
  logic [CNT_N-1:0] wr_en;
  cnt_vec_t cnt;

  assign wr      = bus_valid_i & bus_we_i;
  assign rd      = bus_valid_i & ~bus_we_i;
  assign clr     = wr && bus_addr_i == ADR_CLR && bus_wdata_i == CLR_KEY;
  assign go      = wr && bus_addr_i == ADR_GO;
  assign cnt_rd  = rd && bus_addr_i < ADDR_W'(CNT_N);
  assign stat_rd = rd && bus_addr_i == ADR_STAT;

  for (genvar g = 0; g < CNT_N; g++) begin : g_wr
    assign wr_en[g] = wr && bus_addr_i == ADDR_W'(g);
  end

  rtc_time_chain u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .go_i    (go),
    .clr_i   (clr),
    .wr_en_i (wr_en),
    .wdata_i (bus_wdata_i),
    .cnt_o   (cnt)
  );

  rtc_roll_flag u_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .cnt_rd_i  (cnt_rd),
    .stat_rd_i (stat_rd),
    .flag_o    (flag)
  );

  rtc_rd_mux u_mux (
    .rd_i    (rd),
    .addr_i  (bus_addr_i),
    .cnt_i   (cnt),
    .flag_i  (flag),
    .rdata_o (bus_rdata_o)
  );

  p_ms_low_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && bus_addr_i == '0) |-> bus_rdata_o[3:0] == 4'd0);
  p_stat_upper_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |-> bus_rdata_o[7:1] == '0);
endmodule

// File: tb/rtc_bcd_chain_tb.sv
module rtc_bcd_chain_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_ROLL = 12;

  // {start state, expected after one tick}; bytes mon,dom,dow,hr,min,sec,01h,00h
  localparam logic [127:0] ROLL_TBL [N_ROLL] = '{
    {64'h01_01_01_00_00_00_00_00, 64'h01_01_01_00_00_00_00_10}, // R3
    {64'h01_01_01_00_00_00_00_90, 64'h01_01_01_00_00_00_01_00}, // R3
    {64'h01_01_01_00_00_09_99_90, 64'h01_01_01_00_00_10_00_00}, // R3
    {64'h01_01_01_00_00_59_99_90, 64'h01_01_01_00_01_00_00_00}, // R3
    {64'h01_01_01_09_59_59_99_90, 64'h01_01_01_10_00_00_00_00}, // R3
    {64'h01_15_03_23_59_59_99_90, 64'h01_16_04_00_00_00_00_00}, // R4
    {64'h01_15_07_23_59_59_99_90, 64'h01_16_01_00_00_00_00_00}, // R4
    {64'h02_28_02_23_59_59_99_90, 64'h03_01_03_00_00_00_00_00}, // R5
    {64'h04_30_05_23_59_59_99_90, 64'h05_01_06_00_00_00_00_00}, // R5
    {64'h01_30_05_23_59_59_99_90, 64'h01_31_06_00_00_00_00_00}, // R5
    {64'h09_30_01_23_59_59_99_90, 64'h10_01_02_00_00_00_00_00}, // R5
    {64'h12_31_06_23_59_59_99_90, 64'h01_01_07_00_00_00_00_00}  // R5
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic valid = 1'b0, we = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rdata, rv;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_bcd_chain u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_valid_i(valid),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); valid = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); valid = 0; we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); valid = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); valid = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic load(input logic [63:0] v);
    for (int i = 0; i < 8; i++) wr(5'(i), v[8*i +: 8]);
  endtask

  task automatic expect_all(input string tag, input logic [63:0] v);
    for (int i = 0; i < 8; i++) begin
      rd(5'(i), rv);
      check($sformatf("%s byte %0d", tag, i), rv, v[8*i +: 8]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    expect_all("R1 reset", 64'h01_01_01_00_00_00_00_00);
    rd(5'h14, rv); check("R1 flag reset", rv, 8'h00);

    // roll table: one tick from each start state
    for (int k = 0; k < N_ROLL; k++) begin
      load(ROLL_TBL[k][127:64]);
      ticks(1);
      expect_all($sformatf("R3/R4/R5 row %0d", k), ROLL_TBL[k][63:0]);
    end

    // R2 masks
    for (int i = 0; i < 8; i++) begin
      logic [7:0] m;
      m = (i == 0) ? 8'hF0 : (i == 1) ? 8'hFF : (i <= 3) ? 8'h7F :
          (i == 4) ? 8'h3F : (i == 5) ? 8'h07 : (i == 6) ? 8'h3F : 8'h1F;
      wr(5'(i), 8'hFF); rd(5'(i), rv);
      check($sformatf("R2 mask addr %0d", i), rv, m);
    end

    // R10 unmapped reads
    rd(5'h09, rv); check("R10 addr 09", rv, 8'h00);
    rd(5'h1F, rv); check("R10 addr 1F", rv, 8'h00);

    // R6 write beats tick
    wr(5'h00, 8'h30);
    @(negedge clk); valid = 1; we = 1; addr = 5'h00; wdata = 8'h50; tick = 1;
    @(negedge clk); valid = 0; we = 0; tick = 0;
    rd(5'h00, rv); check("R6 write over tick", rv, 8'h50);

    // R7 counters reset command
    load(64'h05_12_03_14_45_22_33_40);
    wr(5'h12, 8'h7E);
    expect_all("R7 non-key ignored", 64'h05_12_03_14_45_22_33_40);
    wr(5'h12, 8'hFF);
    expect_all("R7 key resets", 64'h01_01_01_00_00_00_00_00);

    // R8 minute-start command
    load(64'h05_12_03_14_10_45_33_50);
    wr(5'h15, 8'h00);
    expect_all("R8 sec 45", 64'h05_12_03_14_11_00_00_00);
    load(64'h05_12_03_14_10_39_33_50);
    wr(5'h15, 8'hA5);
    expect_all("R8 sec 39", 64'h05_12_03_14_10_00_00_00);
    load(64'h05_12_03_05_59_50_00_00);
    wr(5'h15, 8'h00);
    expect_all("R8 carry to hour", 64'h05_12_03_06_00_00_00_00);

    // R9 rollover flag
    rd(5'h14, rv);
    ticks(1);
    rd(5'h14, rv); check("R9 tick without read", rv, 8'h00);
    rd(5'h03, rv);
    rd(5'h14, rv); check("R9 read no tick", rv, 8'h00);
    rd(5'h03, rv);
    ticks(2);
    rd(5'h14, rv); check("R9 tick after read", rv, 8'h01);
    rd(5'h14, rv); check("R9 cleared by status read", rv, 8'h00);
    ticks(1);
    rd(5'h14, rv); check("R9 stays clear", rv, 8'h00);
    @(negedge clk); valid = 1; we = 0; addr = 5'h02; tick = 1;
    @(negedge clk); valid = 0; tick = 0;
    rd(5'h14, rv); check("R9 tick same cycle", rv, 8'h01);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule